// File: doc/BRIEF.md
# Multicycle Stored-Program Core

This block is a small 16-bit processor core that runs a program held in its own word-addressed memory. A control state machine takes every instruction through up to six phases: fetch, decode, address evaluation, operand fetch, execute and store result. Phases an instruction has no use for are skipped, so instructions differ in length. Every access to the single memory port passes through a memory address register and a memory data register. The memory returns read data into the data register one cycle after the read strobe.

The core holds eight 16-bit general registers, a program counter, an instruction register and an ALU. It runs register-to-register add, bitwise AND and bitwise NOT, plus load and store with a base register and a signed six-bit offset. Any other opcode passes through decode and does nothing. While reset is high, a load port fills the memory with the program and its data. After reset the core starts fetching at address 0. The core's state is visible through the memory strobes, the address and data registers, the program counter, a phase code, a pulse that marks the last cycle of each instruction, and the register file write port.

Top module: `spc_core`

## Requirements
- R1: A synchronous active-high reset sets the program counter to 0, clears all eight registers to 0 and puts the machine in the first fetch cycle. On the cycle after reset, phase_o = 0 and pc_o = 0.
- R2: Fetch takes three cycles. In the first cycle MAR is loaded from the PC. In the second, mem_rd_o is high and mar_o equals the PC. In the third, IR is loaded from MDR and the PC is incremented by 1, so pc_o shows the old PC + 1 from the decode cycle on.
- R3: Opcode 4'b0001 (ADD) writes R[ins[8:6]] + R[ins[2:0]] modulo 2^16 to R[ins[11:9]].
- R4: Opcode 4'b0101 (AND) writes R[ins[8:6]] & R[ins[2:0]] to R[ins[11:9]].
- R5: Opcode 4'b1001 (NOT) writes ~R[ins[8:6]] to R[ins[11:9]]. The low bits of the instruction are not used.
- R6: Opcode 4'b0110 (load) forms the address R[ins[8:6]] + sign-extended ins[5:0]. In the operand cycle it shows that address on mar_o with mem_rd_o high, and it writes memory word address[7:0] to R[ins[11:9]].
- R7: Opcode 4'b0111 (store) forms the address in the same way. In its store-result cycle it raises mem_wr_o, with mar_o equal to the address and mdr_o equal to R[ins[11:9]], and memory word address[7:0] takes that value.
- R8: Any other opcode takes four cycles (three fetch cycles and decode). It writes neither a register nor memory, and the next fetch starts at PC + 1.
- R9: Phase codes are fetch=0, decode=1, evaluate address=2, fetch operands=3, execute=4, store result=5. ALU instructions show the sequence 0,0,0,1,3,4,5. Load and store show 0,0,0,1,2,3,5.
- R10: Registers and memory change only in the store-result cycle, and there is at most one write there. retire_o is high for exactly the last cycle of every instruction and low in all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_we | input | 1 | Program load write enable, honoured only while rst is high |
| load_addr | input | 8 | Program load word address |
| load_data | input | 16 | Program load word |
| pc_o | output | 16 | Program counter |
| mar_o | output | 16 | Memory address register |
| mdr_o | output | 16 | Memory data register |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| phase_o | output | 3 | Current instruction phase code |
| retire_o | output | 1 | Last cycle of the current instruction |
| rf_wr_en_o | output | 1 | Register file write enable |
| rf_wr_idx_o | output | 3 | Register file write index |
| rf_wr_data_o | output | 16 | Register file write data |

## Verification
A state machine that takes a wrong turn shows at once: phase_o departs from the expected sequence in that same cycle, and retire_o comes at the wrong cycle. A bad program counter first appears on mar_o during the read cycle of the next fetch, which is at most seven cycles later. A corrupted register, or a memory word that was written wrongly, stays hidden until a later instruction reads it. It then surfaces as a wrong value on the register write port or on the store data, which may be many instructions after the fault. The bench therefore runs long random programs against an instruction-level model and compares every write.

// File: rtl/spc_pkg.sv
package spc_pkg;

    localparam int WORD_W  = 16;
    localparam int REG_CNT = 8;
    localparam int IDX_W   = $clog2(REG_CNT);
    localparam int OFF_W   = 6;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [IDX_W-1:0]  ridx_t;

    localparam logic [3:0] OPC_ADD = 4'b0001;
    localparam logic [3:0] OPC_AND = 4'b0101;
    localparam logic [3:0] OPC_NOT = 4'b1001;
    localparam logic [3:0] OPC_LDR = 4'b0110;
    localparam logic [3:0] OPC_STR = 4'b0111;

    typedef enum logic [2:0] {
        ST_F_ADDR, ST_F_READ, ST_F_LATCH, ST_DECODE,
        ST_EVAL, ST_OPND, ST_EXEC, ST_STORE
    } state_e;

    typedef enum logic [2:0] {
        PH_FETCH  = 3'd0,
        PH_DECODE = 3'd1,
        PH_EVAL   = 3'd2,
        PH_OPND   = 3'd3,
        PH_EXEC   = 3'd4,
        PH_STORE  = 3'd5
    } phase_e;

    typedef enum logic [1:0] {K_ALU, K_LOAD, K_STORE, K_NONE} kind_e;

    typedef struct packed {
        logic [3:0]       opc;
        ridx_t            dst;
        ridx_t            src1;
        logic [OFF_W-1:0] low;
    } insn_t;

    function automatic kind_e classify(logic [3:0] opc);
        case (opc)
            OPC_ADD, OPC_AND, OPC_NOT: return K_ALU;
            OPC_LDR:                   return K_LOAD;
            OPC_STR:                   return K_STORE;
            default:                   return K_NONE;
        endcase
    endfunction

    function automatic word_t sext_off(logic [OFF_W-1:0] v);
        return {{(WORD_W-OFF_W){v[OFF_W-1]}}, v};
    endfunction

    function automatic word_t alu_op(logic [3:0] opc, word_t a, word_t b);
        case (opc)
            OPC_ADD: return a + b;
            OPC_AND: return a & b;
            OPC_NOT: return ~a;
            default: return '0;
        endcase
    endfunction

    function automatic phase_e phase_of(state_e s);
        case (s)
            ST_DECODE: return PH_DECODE;
            ST_EVAL:   return PH_EVAL;
            ST_OPND:   return PH_OPND;
            ST_EXEC:   return PH_EXEC;
            ST_STORE:  return PH_STORE;
            default:   return PH_FETCH;
        endcase
    endfunction

endpackage

// File: rtl/spc_regfile.sv
module spc_regfile
    import spc_pkg::*;
#(
    parameter int W = WORD_W,
    parameter int N = REG_CNT,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [IW-1:0] ra_a,
    input  logic [IW-1:0] ra_b,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b,
    input  logic          we,
    input  logic [IW-1:0] wa,
    input  logic [W-1:0]  wd
);

    logic [W-1:0] regs [N];

    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (rst) begin
                regs[i] <= '0;
            end else if (we && wa == IW'(i)) begin
                regs[i] <= wd;
            end
        end
    end

    assign rd_a = regs[ra_a];
    assign rd_b = regs[ra_b];

endmodule

// File: rtl/spc_mem.sv
module spc_mem #(
    parameter int W  = 16,
    parameter int AW = 8,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic [AW-1:0] addr,
    output logic [W-1:0]  rdata,
    input  logic          we,
    input  logic [W-1:0]  wdata,
    input  logic          ld_we,
    input  logic [AW-1:0] ld_addr,
    input  logic [W-1:0]  ld_data
);

    logic [W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[addr] <= wdata;
        end else if (ld_we) begin
            cells[ld_addr] <= ld_data;
        end
    end

    assign rdata = cells[addr];

endmodule

// File: rtl/spc_ctrl.sv
module spc_ctrl
    import spc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  kind_e  kind,
    output state_e state
);

    state_e nxt;

    always_comb begin
        case (state)
            ST_F_ADDR:  nxt = ST_F_READ;
            ST_F_READ:  nxt = ST_F_LATCH;
            ST_F_LATCH: nxt = ST_DECODE;
            ST_DECODE: begin
                case (kind)
                    K_ALU:           nxt = ST_OPND;
                    K_LOAD, K_STORE: nxt = ST_EVAL;
                    default:         nxt = ST_F_ADDR;
                endcase
            end
            ST_EVAL:    nxt = ST_OPND;
            ST_OPND:    nxt = (kind == K_ALU) ? ST_EXEC : ST_STORE;
            ST_EXEC:    nxt = ST_STORE;
            default:    nxt = ST_F_ADDR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_F_ADDR;
        end else begin
            state <= nxt;
        end
    end

endmodule

// File: rtl/spc_core.sv
module spc_core
    import spc_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_we,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [WORD_W-1:0] load_data,
    output logic [WORD_W-1:0] pc_o,
    output logic [WORD_W-1:0] mar_o,
    output logic [WORD_W-1:0] mdr_o,
    output logic              mem_rd_o,
    output logic              mem_wr_o,
    output logic [2:0]        phase_o,
    output logic              retire_o,
    output logic              rf_wr_en_o,
    output logic [IDX_W-1:0]  rf_wr_idx_o,
    output logic [WORD_W-1:0] rf_wr_data_o
);

    state_e state;
    word_t  pc_q, ir_q, mar_q, mdr_q, opa_q, opb_q, tmp_q;
    word_t  mem_rdata, rd_a, rd_b;
    insn_t  ins;
    kind_e  kind;
    ridx_t  rb_idx;

    assign ins    = insn_t'(ir_q);
    assign kind   = classify(ins.opc);
    assign rb_idx = (kind == K_STORE) ? ins.dst : ins.low[IDX_W-1:0];

    spc_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .kind  (kind),
        .state (state)
    );

    spc_regfile #(.W(WORD_W), .N(REG_CNT)) u_rf (
        .clk  (clk),
        .rst  (rst),
        .ra_a (ins.src1),
        .ra_b (rb_idx),
        .rd_a (rd_a),
        .rd_b (rd_b),
        .we   (rf_wr_en_o),
        .wa   (rf_wr_idx_o),
        .wd   (rf_wr_data_o)
    );

    spc_mem #(.W(WORD_W), .AW(ADDR_W)) u_mem (
        .clk     (clk),
        .addr    (mar_q[ADDR_W-1:0]),
        .rdata   (mem_rdata),
        .we      (mem_wr_o),
        .wdata   (mdr_q),
        .ld_we   (load_we & rst),
        .ld_addr (load_addr),
        .ld_data (load_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            ir_q  <= '0;
            mar_q <= '0;
            mdr_q <= '0;
            opa_q <= '0;
            opb_q <= '0;
            tmp_q <= '0;
        end else begin
            case (state)
                ST_F_ADDR:  mar_q <= pc_q;
                ST_F_READ:  mdr_q <= mem_rdata;
                ST_F_LATCH: begin
                    ir_q <= mdr_q;
                    pc_q <= pc_q + word_t'(1);
                end
                ST_EVAL:    mar_q <= rd_a + sext_off(ins.low);
                ST_OPND: begin
                    case (kind)
                        K_ALU: begin
                            opa_q <= rd_a;
                            opb_q <= rd_b;
                        end
                        K_LOAD:  mdr_q <= mem_rdata;
                        K_STORE: mdr_q <= rd_b;
                        default: ;
                    endcase
                end
                ST_EXEC:    tmp_q <= alu_op(ins.opc, opa_q, opb_q);
                default: ;
            endcase
        end
    end

    assign mem_rd_o     = (state == ST_F_READ) || (state == ST_OPND && kind == K_LOAD);
    assign mem_wr_o     = (state == ST_STORE) && (kind == K_STORE);
    assign rf_wr_en_o   = (state == ST_STORE) && (kind == K_ALU || kind == K_LOAD);
    assign rf_wr_idx_o  = ins.dst;
    assign rf_wr_data_o = (kind == K_LOAD) ? mdr_q : tmp_q;
    assign retire_o     = (state == ST_STORE) || (state == ST_DECODE && kind == K_NONE);
    assign phase_o      = phase_of(state);
    assign pc_o         = pc_q;
    assign mar_o        = mar_q;
    assign mdr_o        = mdr_q;

endmodule

// File: rtl/spc_core_chk.sv
module spc_core_chk
    import spc_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input state_e state,
    input word_t  pc,
    input word_t  mar,
    input logic   rd,
    input logic   wr,
    input logic   rf_we,
    input logic   retire,
    input logic [2:0] phase
);

    p_fetch_addr_r2: assert property (@(posedge clk) disable iff (rst)
        state == ST_F_READ |-> (mar == pc) && rd);

    p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
        state == ST_F_LATCH |=> pc == word_t'($past(pc) + word_t'(1)));

    p_pc_hold_r10: assert property (@(posedge clk) disable iff (rst)
        state != ST_F_LATCH |=> $stable(pc));

    p_rf_store_only_r10: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> phase == 3'd5);

    p_mem_wr_store_only_r7: assert property (@(posedge clk) disable iff (rst)
        wr |-> (phase == 3'd5) && !rd && !rf_we);

    p_retire_single_r10: assert property (@(posedge clk) disable iff (rst)
        retire |=> !retire);

    p_store_then_fetch_r9: assert property (@(posedge clk) disable iff (rst)
        phase == 3'd5 |=> state == ST_F_ADDR);

    p_latch_then_decode_r9: assert property (@(posedge clk) disable iff (rst)
        state == ST_F_LATCH |=> phase == 3'd1);

endmodule

bind spc_core spc_core_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .state  (state),
    .pc     (pc_q),
    .mar    (mar_q),
    .rd     (mem_rd_o),
    .wr     (mem_wr_o),
    .rf_we  (rf_wr_en_o),
    .retire (retire_o),
    .phase  (phase_o)
);

// File: tb/test_spc_core.sv
`timescale 1ns/1ps
module test_spc_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_we = 1'b0;
    logic [7:0]  load_addr = '0;
    logic [15:0] load_data = '0;
    logic [15:0] pc_o, mar_o, mdr_o, rf_wr_data_o;
    logic        mem_rd_o, mem_wr_o, retire_o, rf_wr_en_o;
    logic [2:0]  phase_o, rf_wr_idx_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [15:0] mdl_mem [256];
    logic [15:0] mdl_rf  [8];
    logic [15:0] mdl_pc;

    always #2 clk = ~clk;

    spc_core i_spc_core (
        .clk(clk), .rst(rst), .load_we(load_we), .load_addr(load_addr),
        .load_data(load_data), .pc_o(pc_o), .mar_o(mar_o), .mdr_o(mdr_o),
        .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o), .phase_o(phase_o),
        .retire_o(retire_o), .rf_wr_en_o(rf_wr_en_o),
        .rf_wr_idx_o(rf_wr_idx_o), .rf_wr_data_o(rf_wr_data_o)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] enc(logic [3:0] opc, logic [2:0] dr,
                                        logic [2:0] s1, logic [5:0] low);
        return {opc, dr, s1, low};
    endfunction

    function automatic logic [15:0] rand_insn();
        int pick;
        logic [3:0] o;
        pick = int'($urandom_range(0, 9));
        case (pick)
            0, 1, 8: o = 4'b0001;
            2:       o = 4'b0101;
            3:       o = 4'b1001;
            4, 5, 9: o = 4'b0110;
            6:       o = 4'b0111;
            default: begin
                o = 4'($urandom_range(0, 15));
                while (o == 4'b0001 || o == 4'b0101 || o == 4'b1001 ||
                       o == 4'b0110 || o == 4'b0111)
                    o = 4'($urandom_range(0, 15));
            end
        endcase
        return {o, 12'($urandom())};
    endfunction

    // One instruction: predict from the model, then watch every cycle of it.
    task automatic run_insn();
        logic [15:0] w, a, b, res, addr, off;
        logic [3:0]  opc;
        logic [2:0]  dr, s1, s2;
        logic [2:0]  ph [7];
        int          len;
        int          kind;   // 0 alu, 1 load, 2 store, 3 none
        string       tag;
        w   = mdl_mem[mdl_pc[7:0]];
        opc = w[15:12];
        dr  = w[11:9];
        s1  = w[8:6];
        s2  = w[2:0];
        off = {{10{w[5]}}, w[5:0]};
        a   = mdl_rf[s1];
        b   = mdl_rf[s2];
        addr = a + off;
        res = '0;
        tag = "R8";
        case (opc)
            4'b0001: begin kind = 0; res = a + b; tag = "R3"; end
            4'b0101: begin kind = 0; res = a & b; tag = "R4"; end
            4'b1001: begin kind = 0; res = ~a;    tag = "R5"; end
            4'b0110: begin kind = 1; res = mdl_mem[addr[7:0]]; tag = "R6"; end
            4'b0111: begin kind = 2; res = mdl_rf[dr]; tag = "R7"; end
            default: kind = 3;
        endcase
        ph[0] = 3'd0; ph[1] = 3'd0; ph[2] = 3'd0; ph[3] = 3'd1;
        if (kind == 0) begin
            len = 7; ph[4] = 3'd3; ph[5] = 3'd4; ph[6] = 3'd5;
        end else if (kind == 3) begin
            len = 4; ph[4] = 3'd0; ph[5] = 3'd0; ph[6] = 3'd0;
        end else begin
            len = 7; ph[4] = 3'd2; ph[5] = 3'd3; ph[6] = 3'd5;
        end
        for (int c = 0; c < len; c++) begin
            @(negedge clk);
            chk(phase_o == ph[c], (kind == 3) ? "R8" : "R9", "phase", 16'(phase_o), 16'(ph[c]));
            chk(retire_o == (c == len - 1), "R10", "retire", 16'(retire_o), 16'(c == len - 1));
            if (c != len - 1)
                chk(!rf_wr_en_o && !mem_wr_o, "R10", "early write",
                    {14'd0, rf_wr_en_o, mem_wr_o}, 16'd0);
            if (c == 0) chk(pc_o == mdl_pc, "R2", "pc at fetch", pc_o, mdl_pc);
            if (c == 1) begin
                chk(mem_rd_o == 1'b1, "R2", "fetch read strobe", 16'(mem_rd_o), 16'd1);
                chk(mar_o == mdl_pc, "R2", "fetch mar", mar_o, mdl_pc);
            end
            if (c == 3) chk(pc_o == mdl_pc + 16'd1, "R2", "pc after fetch", pc_o, mdl_pc + 16'd1);
            if (kind == 1 && c == 5) begin
                chk(mem_rd_o == 1'b1, "R6", "load read strobe", 16'(mem_rd_o), 16'd1);
                chk(mar_o == addr, "R6", "load address", mar_o, addr);
            end
            if (c == len - 1) begin
                if (kind <= 1) begin
                    chk(rf_wr_en_o == 1'b1, tag, "reg write enable", 16'(rf_wr_en_o), 16'd1);
                    chk(rf_wr_idx_o == dr, tag, "reg write index", 16'(rf_wr_idx_o), 16'(dr));
                    chk(rf_wr_data_o == res, tag, "reg write data", rf_wr_data_o, res);
                    chk(mem_wr_o == 1'b0, "R10", "stray mem write", 16'(mem_wr_o), 16'd0);
                end else if (kind == 2) begin
                    chk(mem_wr_o == 1'b1, "R7", "write strobe", 16'(mem_wr_o), 16'd1);
                    chk(mar_o == addr, "R7", "store address", mar_o, addr);
                    chk(mdr_o == res, "R7", "store data", mdr_o, res);
                    chk(rf_wr_en_o == 1'b0, "R7", "stray reg write", 16'(rf_wr_en_o), 16'd0);
                end else begin
                    chk(!rf_wr_en_o && !mem_wr_o, "R8", "no-op write",
                        {14'd0, rf_wr_en_o, mem_wr_o}, 16'd0);
                end
            end
        end
        mdl_pc = mdl_pc + 16'd1;
        if (kind <= 1) mdl_rf[dr] = res;
        if (kind == 2) mdl_mem[addr[7:0]] = res;
    endtask

    task automatic do_reset_check();
        @(posedge clk);
        #1 rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(pc_o == 16'd0, "R1", "pc in reset", pc_o, 16'd0);
        chk(phase_o == 3'd0, "R1", "phase in reset", 16'(phase_o), 16'd0);
        @(posedge clk);
        #1 rst = 1'b0;
        mdl_pc = '0;
        for (int i = 0; i < 8; i++) mdl_rf[i] = '0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int unused_seed;
        unused_seed = int'($urandom(32'd20240));
        for (int i = 0; i < 256; i++) mdl_mem[i] = 16'($urandom());
        for (int i = 11; i < 224; i++) mdl_mem[i] = rand_insn();
        mdl_mem[255] = 16'hFFFF;
        mdl_mem[254] = 16'h0001;
        mdl_mem[253] = 16'h8000;
        // directed start: load extremes, wrap the adder, store and reload
        mdl_mem[0]  = enc(4'b0110, 3'd1, 3'd0, 6'h3F);   // R1 <- mem[-1]
        mdl_mem[1]  = enc(4'b0110, 3'd2, 3'd0, 6'h3E);   // R2 <- mem[-2]
        mdl_mem[2]  = enc(4'b0110, 3'd3, 3'd0, 6'h3D);   // R3 <- mem[-3]
        mdl_mem[3]  = enc(4'b0001, 3'd4, 3'd1, 6'h02);   // R4 = R1 + R2 wraps
        mdl_mem[4]  = enc(4'b0101, 3'd5, 3'd1, 6'h03);   // R5 = R1 & R3
        mdl_mem[5]  = enc(4'b1001, 3'd6, 3'd3, 6'h3F);   // R6 = ~R3
        mdl_mem[6]  = enc(4'b0111, 3'd1, 3'd0, 6'h36);   // mem[-10] = R1
        mdl_mem[7]  = enc(4'b0110, 3'd7, 3'd0, 6'h36);   // R7 <- mem[-10]
        mdl_mem[8]  = enc(4'b0110, 3'd1, 3'd0, 6'h1F);   // R1 <- mem[31]
        mdl_mem[9]  = 16'hF000;                          // unused opcode
        mdl_mem[10] = enc(4'b0001, 3'd2, 3'd1, 6'h01);   // R2 = R1 + R1

        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            load_we   = 1'b1;
            load_addr = 8'(i);
            load_data = mdl_mem[i];
        end
        @(negedge clk);
        load_we = 1'b0;
        @(negedge clk);
        chk(pc_o == 16'd0, "R1", "pc in reset", pc_o, 16'd0);
        chk(phase_o == 3'd0, "R1", "phase in reset", 16'(phase_o), 16'd0);
        @(posedge clk);
        #1 rst = 1'b0;
        mdl_pc = '0;
        for (int i = 0; i < 8; i++) mdl_rf[i] = '0;

        for (int n = 0; n < 280; n++) run_insn();

        do_reset_check();
        for (int n = 0; n < 40; n++) run_insn();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule